// File: doc/BRIEF.md
# Command-Gated Serial Register Slave

This block is the slave end of a serial register port for a converter-style device. A host selects the block with an active-low select, clocks bits in on a data input and out on a data output, and sees a data-ready flag. Every access has two phases. The host first shifts in a command byte, which names one of eight register slots and says whether the next transfer reads or writes. The transfer itself follows, and then the block waits for a command again. Six slots are 8-bit configuration registers that feed the converter. One slot is a read-only 24-bit sample register, which the converter side loads through a parallel strobe. The last slot is the command slot itself. Reading it returns the data-ready status in its top bit, so a host that ties select low permanently (three-wire use) can still poll for new samples.

The serial inputs are oversampled on the system clock. A polarity input chooses which serial clock edge is active. Any run of 32 consecutive ones on the data input brings the shifter back to the command phase and leaves every stored value untouched. Raising select in the middle of a transfer throws away the partial bits. The phase that was in effect when the transfer started is kept.

Top module: `cmdgate_serial_slave`

## Requirements
- R1: After reset, drdy_n is 1, dout is 0, every configuration field of cfg_o is 0, and the first byte shifted in is treated as a command.
- R2: Command byte layout: bit 7 must be 0, or the byte is dropped and the block stays in the command phase. Bits 6:4 give the slot address. Bit 3 set to 1 means read and 0 means write. Bits 2:0 are ignored. After the transfer that follows a command completes, the block is back in the command phase. A write command to slot 0 keeps the block in the command phase.
- R3: Writing slot 1, 2, 3, 4, 6 or 7 stores the 8 bits MSB first into cfg_o[8*a +: 8], and reading that slot returns the stored value. No other action changes cfg_o.
- R4: Slot 5 is the sample register. A read shifts out 24 bits MSB first. A write command to it consumes 24 bits, and those bits are discarded.
- R5: Reading slot 0 returns the drdy_n level in bit 7 and the accepted read command's bits 6:0 below it.
- R6: On a sample_load pulse, drdy_n is 1 in the next cycle. In the cycle after that, the sample register holds sample_in and drdy_n is 0.
- R7: When a 24-bit sample read completes, drdy_n is set to 1, unless the sample register was updated at or after the start of that read. In that case drdy_n stays 0. A second read with no update in between returns the same word.
- R8: After 32 consecutive active-edge samples of din equal to 1, the block is in the command phase at bit 0. No register contents change.
- R9: Raising cs_n clears the partial bits and the ones count without committing anything. The phase that was current before the interrupted transfer is kept.
- R10: With pol=1, din is sampled on rising sclk edges and dout changes on falling edges. With pol=0, the edges are swapped.
- R11: dout is 0 outside a read transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial data from the host |
| pol | input | 1 | Active sclk edge: 1 rising, 0 falling |
| dout | output | 1 | Serial data to the host |
| drdy_n | output | 1 | Active-low new-sample flag |
| sample_load | input | 1 | One-cycle strobe that presents a new sample |
| sample_in | input | 24 | Sample word captured on sample_load |
| cfg_o | output | 64 | Eight 8-bit slot values, slot a at bits 8a+7:8a (slots 0 and 5 read as 0) |

## Verification
The risky overlap is between a new sample landing and the end of a sample read. Both of them drive drdy_n, and they can fall in the same system-clock cycle. The bench pulses sample_load at each offset from 0 to 6 clocks after the final active sclk edge of a read, and also in the middle of a read. This sweeps the load and the update across the cycle where the read completes. In every case it expects drdy_n to end at 0 and the interrupted read to return the previous word. A follow-up read must then return the new word and leave drdy_n at 1.

// File: rtl/ser_pkg.sv
package ser_pkg;

  localparam int CMD_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_t;

  // Command byte accepted only when its top bit is clear.
  function automatic logic cmd_ok(input logic [CMD_W-1:0] b);
    return ~b[CMD_W-1];
  endfunction

  function automatic logic [ADDR_W-1:0] cmd_addr(input logic [CMD_W-1:0] b);
    return b[6:4];
  endfunction

  function automatic logic cmd_is_rd(input logic [CMD_W-1:0] b);
    return b[3];
  endfunction

  // Number of serial bits in the transfer after a command.
  function automatic int xfer_bits(input logic [ADDR_W-1:0] a, input int data_addr,
                                   input int data_w);
    return (int'(a) == data_addr) ? data_w : CMD_W;
  endfunction

endpackage

// File: rtl/ser_sync_edge.sv
module ser_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  input  logic pol,
  output logic sel,
  output logic din_s,
  output logic act_edge,
  output logic inact_edge
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclk_q, cs_q, din_q;
  logic         sclk_d;
  logic         rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      din_q  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[TOP-1:0], sclk};
      cs_q   <= {cs_q[TOP-1:0], cs_n};
      din_q  <= {din_q[TOP-1:0], din};
      sclk_d <= sclk_q[TOP];
    end
  end

  assign rise       = sclk_q[TOP] & ~sclk_d;
  assign fall       = ~sclk_q[TOP] & sclk_d;
  assign sel        = ~cs_q[TOP];
  assign din_s      = din_q[TOP];
  assign act_edge   = sel & (pol ? rise : fall);
  assign inact_edge = sel & (pol ? fall : rise);
endmodule

// File: rtl/ser_ones_det.sv
module ser_ones_det #(
  parameter int RUN_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic act_edge,
  input  logic din_s,
  output logic resync
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic [CNT_W-1:0] cnt_q;

  assign resync = act_edge & din_s & (cnt_q == CNT_W'(RUN_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!sel)             cnt_q <= '0;
    else if (act_edge) begin
      if (!din_s || resync)    cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ser_out_reg.sv
module ser_out_reg #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_load,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              rd_start,
  input  logic              rd_done,
  output logic [DATA_W-1:0] data_q,
  output logic              drdy_n,
  output logic              upd_now
);
  logic [DATA_W-1:0] stage_q;
  logic              pend_q;
  logic              dirty_q;

  assign upd_now = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      pend_q  <= 1'b0;
      data_q  <= '0;
      dirty_q <= 1'b0;
      drdy_n  <= 1'b1;
    end else begin
      pend_q <= sample_load;
      if (sample_load) stage_q <= sample_in;
      if (pend_q)      data_q  <= stage_q;
      if (rd_start)     dirty_q <= pend_q;
      else if (pend_q)  dirty_q <= 1'b1;
      if (sample_load)                drdy_n <= 1'b1;
      else if (pend_q)                drdy_n <= 1'b0;
      else if (rd_done && !dirty_q)   drdy_n <= 1'b1;
    end
  end
endmodule

// File: rtl/cmdgate_serial_slave.sv
module cmdgate_serial_slave
  import ser_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int DATA_ADDR   = 5,
  parameter int RUN_LEN     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sclk,
  input  logic                           cs_n,
  input  logic                           din,
  input  logic                           pol,
  output logic                           dout,
  output logic                           drdy_n,
  input  logic                           sample_load,
  input  logic [DATA_W-1:0]              sample_in,
  output logic [(1<<ADDR_W)*CMD_W-1:0]   cfg_o
);
  localparam int REG_NUM  = 1 << ADDR_W;
  localparam int CMD_ADDR = 0;
  localparam int CNT_W    = $clog2(DATA_W + 1);
  localparam int PAD_W    = DATA_W - CMD_W;

  logic sel, din_s, act_edge, inact_edge, resync, upd_now;
  logic [DATA_W-1:0] data_q;

  ser_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .pol(pol),
    .sel(sel), .din_s(din_s), .act_edge(act_edge), .inact_edge(inact_edge));

  ser_ones_det #(.RUN_LEN(RUN_LEN)) u_ones (
    .clk(clk), .rst_n(rst_n), .sel(sel), .act_edge(act_edge), .din_s(din_s),
    .resync(resync));

  phase_t              phase_q;
  logic [CNT_W-1:0]    bitcnt_q;
  logic [CMD_W-2:0]    sh_in_q;
  logic [ADDR_W-1:0]   tgt_q;
  logic [DATA_W-1:0]   sh_out_q;
  logic                dout_q;
  logic [CMD_W-1:0]    regs [REG_NUM];

  logic [CMD_W-1:0]    new_byte;
  logic [CNT_W-1:0]    last_idx, out_idx;
  logic                byte_done, accept, cmd_reject, wr_commit, rd_start, rd_done;
  logic [DATA_W-1:0]   rd_word;
  logic [ADDR_W-1:0]   req_addr;

  assign new_byte   = {sh_in_q, din_s};
  assign req_addr   = cmd_addr(new_byte);
  assign last_idx   = (phase_q == PH_CMD) ? CNT_W'(CMD_W - 1)
                                          : CNT_W'(xfer_bits(tgt_q, DATA_ADDR, DATA_W) - 1);
  assign byte_done  = act_edge && !resync && (bitcnt_q == last_idx);
  assign accept     = byte_done && (phase_q == PH_CMD) && cmd_ok(new_byte);
  assign cmd_reject = byte_done && (phase_q == PH_CMD) && !cmd_ok(new_byte);
  assign wr_commit  = byte_done && (phase_q == PH_WR);
  assign rd_start   = accept && cmd_is_rd(new_byte) && (int'(req_addr) == DATA_ADDR);
  assign rd_done    = byte_done && (phase_q == PH_RD) && (int'(tgt_q) == DATA_ADDR);
  assign out_idx    = CNT_W'(DATA_W - 1) - bitcnt_q;

  always_comb begin
    if (int'(req_addr) == DATA_ADDR)      rd_word = data_q;
    else if (int'(req_addr) == CMD_ADDR)  rd_word = {drdy_n, new_byte[CMD_W-2:0], {PAD_W{1'b0}}};
    else                                  rd_word = {regs[req_addr], {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_CMD;
      bitcnt_q <= '0;
      sh_in_q  <= '0;
      tgt_q    <= '0;
      sh_out_q <= '0;
      dout_q   <= 1'b0;
    end else if (!sel) begin
      bitcnt_q <= '0;
      dout_q   <= 1'b0;
    end else if (resync) begin
      bitcnt_q <= '0;
      phase_q  <= PH_CMD;
    end else if (act_edge) begin
      sh_in_q <= new_byte[CMD_W-2:0];
      if (byte_done) begin
        bitcnt_q <= '0;
        if (phase_q == PH_CMD) begin
          if (cmd_ok(new_byte)) begin
            tgt_q <= req_addr;
            if (cmd_is_rd(new_byte)) begin
              phase_q  <= PH_RD;
              sh_out_q <= rd_word;
            end else if (int'(req_addr) == CMD_ADDR) begin
              phase_q <= PH_CMD;
            end else begin
              phase_q <= PH_WR;
            end
          end
        end else begin
          phase_q <= PH_CMD;
        end
      end else begin
        bitcnt_q <= bitcnt_q + 1'b1;
      end
    end else if (inact_edge) begin
      dout_q <= (phase_q == PH_RD) ? sh_out_q[out_idx] : 1'b0;
    end
  end

  for (genvar i = 0; i < REG_NUM; i++) begin : g_slot
    if (i == CMD_ADDR || i == DATA_ADDR) begin : g_fixed
      assign regs[i] = '0;
    end else begin : g_cfg
      logic [CMD_W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  val_q <= '0;
        else if (wr_commit && int'(tgt_q) == i)      val_q <= new_byte;
      end
      assign regs[i] = val_q;
    end
    assign cfg_o[i*CMD_W +: CMD_W] = regs[i];
  end

  ser_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .sample_load(sample_load), .sample_in(sample_in),
    .rd_start(rd_start), .rd_done(rd_done), .data_q(data_q), .drdy_n(drdy_n),
    .upd_now(upd_now));

  assign dout = dout_q;
endmodule

// File: rtl/ser_slave_chk.sv
module ser_slave_chk
  import ser_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int CFG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             sample_load,
  input logic             upd_now,
  input logic             drdy_n,
  input logic             resync,
  input logic             cmd_reject,
  input logic             wr_commit,
  input phase_t           phase_q,
  input logic [CNT_W-1:0] bitcnt_q,
  input logic [CFG_W-1:0] cfg_o
);
  AST_PRE_UPDATE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_load |=> drdy_n); // R6
  AST_UPDATE_LOWERS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_now && !sample_load) |=> !drdy_n); // R6
  AST_REJECT_STAYS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> (phase_q == PH_CMD)); // R2
  AST_CFG_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(cfg_o)); // R3
  AST_RESYNC_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (phase_q == PH_CMD && bitcnt_q == '0)); // R8
  AST_RESYNC_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> $stable(cfg_o)); // R8
  AST_DESELECT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (bitcnt_q == '0 && $stable(phase_q))); // R9
endmodule

bind cmdgate_serial_slave ser_slave_chk #(.CNT_W(CNT_W), .CFG_W(REG_NUM*ser_pkg::CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .sample_load(sample_load), .upd_now(upd_now),
  .drdy_n(drdy_n), .resync(resync), .cmd_reject(cmd_reject), .wr_commit(wr_commit),
  .phase_q(phase_q), .bitcnt_q(bitcnt_q), .cfg_o(cfg_o));

// File: tb/cmdgate_serial_slave_tb.sv
module cmdgate_serial_slave_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0, pol = 1'b1;
  logic sample_load = 1'b0;
  logic [23:0] sample_in = '0;
  logic dout, drdy_n;
  logic [63:0] cfg_o;
  int nvec = 0, nfail = 0;
  bit done = 0;

  logic [7:0]  cfg_m [8];
  logic [23:0] data_m = '0;
  logic        drdy_m = 1'b1;

  always #10 clk = ~clk;

  cmdgate_serial_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .pol(pol),
    .dout(dout), .drdy_n(drdy_n), .sample_load(sample_load), .sample_in(sample_in),
    .cfg_o(cfg_o));

  function automatic logic [7:0] mk_cmd(input int a, input bit rd);
    return {1'b0, 3'(a), rd, 3'b000};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [23:0] tx, output logic [23:0] rx,
                      input int pbit = -1, input int poff = 0, input logic [23:0] pval = '0);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); din = tx[n-1-i];
      repeat (7) @(negedge clk);
      rx = {rx[22:0], dout};
      sclk = pol;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        sample_load = (i == pbit) && (c == poff);
        sample_in   = pval;
      end
      sclk = ~pol;
    end
    @(negedge clk); sample_load = 1'b0; din = 1'b0;
  endtask

  task automatic wr_slot(input int a, input logic [7:0] v);
    logic [23:0] rx;
    xfer(8, 24'(mk_cmd(a, 0)), rx);
    xfer(8, 24'(v), rx);
    if (a != 0 && a != 5) cfg_m[a] = v;
  endtask

  task automatic rd_slot(input int a, output logic [7:0] v);
    logic [23:0] rx;
    xfer(8, 24'(mk_cmd(a, 1)), rx);
    xfer(8, '0, rx);
    v = rx[7:0];
  endtask

  task automatic rd_data(output logic [23:0] v, input int pbit = -1, input int poff = 0,
                         input logic [23:0] pval = '0);
    logic [23:0] rx;
    xfer(8, 24'(mk_cmd(5, 1)), rx);
    xfer(24, '0, v, pbit, poff, pval);
  endtask

  task automatic load_sample(input logic [23:0] v);
    @(negedge clk); sample_load = 1'b1; sample_in = v;
    @(negedge clk); sample_load = 1'b0;
    repeat (3) @(negedge clk);
    data_m = v; drdy_m = 1'b0;
  endtask

  task automatic set_pol(input logic p);
    @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk); pol = p; sclk = ~p;
    repeat (4) @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  v8;
    logic [23:0] v24, old;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) cfg_m[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 drdy_n", 32'(drdy_n), 1);
    chk("R1 dout", 32'(dout), 0);
    chk("R1 cfg", 32'(cfg_o[31:0] | cfg_o[63:32]), 0);
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);

    // R3 directed and random writes with readback
    for (int a = 1; a < 8; a++) if (a != 5) wr_slot(a, 8'($urandom));
    chk("R11 dout idle after write", 32'(dout), 0);
    for (int a = 1; a < 8; a++) if (a != 5) begin
      chk("R3 cfg field", 32'(cfg_o[8*a +: 8]), 32'(cfg_m[a]));
      rd_slot(a, v8);
      chk("R3 readback", 32'(v8), 32'(cfg_m[a]));
    end

    // R2 rejected command, then a command with reserved bits set
    xfer(8, 24'h0000_A5, v24);
    xfer(8, 24'(mk_cmd(3, 1)), v24);
    xfer(8, '0, v24);
    chk("R2 reject then read", 32'(v24[7:0]), 32'(cfg_m[3]));
    xfer(8, 24'h00_001F, v24);
    xfer(8, '0, v24);
    chk("R2 reserved bits ignored", 32'(v24[7:0]), 32'(cfg_m[1]));
    xfer(8, 24'(mk_cmd(0, 0)), v24);
    rd_slot(2, v8);
    chk("R2 slot0 write stays cmd", 32'(v8), 32'(cfg_m[2]));

    // R5 status via slot 0
    xfer(8, 24'h00_000B, v24); xfer(8, '0, v24);
    chk("R5 status no sample", 32'(v24[7:0]), 32'h8B);

    // R6 update timing
    @(negedge clk); sample_load = 1'b1; sample_in = 24'hA1B2C3;
    @(negedge clk); sample_load = 1'b0;
    chk("R6 flag high before update", 32'(drdy_n), 1);
    @(negedge clk);
    chk("R6 flag low after update", 32'(drdy_n), 0);
    data_m = 24'hA1B2C3; drdy_m = 1'b0;
    xfer(8, 24'h00_000B, v24); xfer(8, '0, v24);
    chk("R5 status ready", 32'(v24[7:0]), 32'h0B);

    // R4/R7 data reads
    rd_data(v24);
    chk("R4 data read", 32'(v24), 32'(data_m));
    repeat (4) @(negedge clk);
    chk("R7 flag after read", 32'(drdy_n), 1);
    rd_data(v24);
    chk("R7 second read same", 32'(v24), 32'(data_m));
    xfer(8, 24'(mk_cmd(5, 0)), v24);
    xfer(24, 24'h123456, v24);
    chk("R11 dout idle", 32'(dout), 0);
    rd_data(v24);
    chk("R4 write discarded", 32'(v24), 32'(data_m));

    // R7 collision sweep: new sample around the end of a read
    for (int off = 0; off < 7; off++) begin
      load_sample(24'($urandom));
      old = data_m;
      v8 = 8'($urandom);
      rd_data(v24, 23, off, {v8, 16'h5A5A});
      repeat (6) @(negedge clk);
      chk("R7 collision read old", 32'(v24), 32'(old));
      chk("R7 collision flag", 32'(drdy_n), 0);
      data_m = {v8, 16'h5A5A};
      rd_data(v24);
      repeat (4) @(negedge clk);
      chk("R7 follow read new", 32'(v24), 32'(data_m));
      chk("R7 follow flag", 32'(drdy_n), 1);
    end
    old = data_m;
    rd_data(v24, 10, 3, 24'hC0FFEE);
    repeat (6) @(negedge clk);
    chk("R7 mid-read update flag", 32'(drdy_n), 0);
    data_m = 24'hC0FFEE;

    // R8 ones resync
    xfer(24, 24'hFFFFFF, v24); xfer(8, 24'hFF, v24);
    chk("R8 cfg unchanged", 32'(cfg_o[31:0]), 32'({cfg_m[3], cfg_m[2], cfg_m[1], 8'h00}));
    rd_slot(2, v8);
    chk("R8 readback after resync", 32'(v8), 32'(cfg_m[2]));
    xfer(8, 24'(mk_cmd(5, 0)), v24);
    xfer(10, '0, v24);
    xfer(24, 24'hFFFFFF, v24); xfer(8, 24'hFF, v24);
    rd_slot(3, v8);
    chk("R8 realigned", 32'(v8), 32'(cfg_m[3]));
    rd_data(v24);
    chk("R8 data kept", 32'(v24), 32'(data_m));

    // R9 abort mid-byte
    xfer(8, 24'(mk_cmd(4, 0)), v24);
    xfer(4, 24'hA, v24);
    @(negedge clk); cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 no commit", 32'(cfg_o[39:32]), 32'(cfg_m[4]));
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    xfer(8, 24'h3C, v24); cfg_m[4] = 8'h3C;
    chk("R9 phase kept", 32'(cfg_o[39:32]), 32'h3C);

    // R10 random polarity mix
    for (int k = 0; k < 16; k++) begin
      int a;
      set_pol(1'($urandom));
      a = 1 + int'($urandom % 7);
      if (a == 5) a = 6;
      wr_slot(a, 8'($urandom));
      rd_slot(a, v8);
      chk("R10 pol readback", 32'(v8), 32'(cfg_m[a]));
      if (k % 4 == 0) begin
        load_sample(24'($urandom));
        rd_data(v24);
        chk("R10 pol data", 32'(v24), 32'(data_m));
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule